// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is a self-running calendar clock reached through a two-byte register window. Software first writes a register number into the index latch at offset 0, then reads the selected value from the data port at offset 1. Offset 0 reads back the latched byte exactly as it was written. Bit 7 of that byte is kept but does not take part in the register decode.

Internally the block counts ticks of a 32768 Hz enable in a sub-second counter. When that counter wraps, it carries into binary seconds, minutes, hours, weekday, day, month and a four-digit year. The calendar applies the real month lengths and the full Gregorian leap-year rule. The time, the two-digit year and a century value can all be read through the data port. So can three status registers. One of them has an update-in-progress flag that is raised briefly at the start of every second. The other two return fixed values that describe the clock's capabilities. Writes to the data port have no effect.

Top module: `rtc_regfile`

## Requirements
- R1: A write with offset 0 stores all 8 bits of `wdata` in the index latch. A read with offset 0 returns that byte unchanged, including bit 7.
- R2: Register selection uses only index bits 6:0. Bit 7 of the index does not change which register a data-port read returns.
- R3: Data-port reads return plain binary time values at these indexes: 0x00 seconds, 0x02 minutes, 0x04 hours (0 to 23), 0x06 weekday (Sunday = 1 through Saturday = 7), 0x07 day of month, 0x08 month (1 to 12) and 0x09 year modulo 100.
- R4: Index 0x32 reads the four-digit year divided by 100, plus one. For example, it reads 21 for 2099 and 22 for 2100.
- R5: Index 0x0A reads rate code 0110 in bits 3:0, time-base code 010 in bits 6:4, and an update-in-progress flag in bit 7. The flag is 1 while fewer than 8 ticks have been counted in the current second, so the register reads 0xA6 in that window and 0x26 at all other times.
- R6: Index 0x0B always reads 0x06, meaning 24-hour mode and binary format. Index 0x0D always reads 0x80, meaning the power-valid bit is set.
- R7: A data-port read of any index not listed in R3 to R6 returns 0x00.
- R8: A write with offset 1 changes neither the index latch nor any calendar value.
- R9: One second spans 2^SUBSEC_W accepted ticks. The sub-second counter and the calendar advance only in cycles where `tick_en` is 1.
- R10: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each carry moves the next field up by one. The weekday advances when the day changes and wraps from 7 to 1.
- R11: Months have 31, 30 or 28 days, as on the calendar. February has 29 days when the year is divisible by 4 and not by 100, or when it is divisible by 400. December 31 rolls over to January 1 of the next year.
- R12: Reset loads the start date and time given by the parameters. It also clears the index latch and the sub-second counter.
- R13: Read data is registered. `rdata` takes the selected value on the clock edge of a read access (`sel`=1, `we`=0) and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per 32768 Hz crystal tick |
| sel | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| offset | input | 1 | 0 = index latch, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A corrupted index latch appears on the very next read of offset 0, and on every data-port read that follows it. A wrong field in the calendar, or a wrong carry out of one, stays hidden until that field is read. It can also stay hidden until the next rollover moves it. The bench therefore starts several instances just before a day, month, year and century boundary, and reads every field one second later. An error in the sub-second counter shows first in the status register A flag, which is checked on both sides of its eight-tick edge. It also shows as a second that arrives one tick too early or too late.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam logic [6:0] IX_SEC   = 7'h00;
   localparam logic [6:0] IX_MIN   = 7'h02;
   localparam logic [6:0] IX_HOUR  = 7'h04;
   localparam logic [6:0] IX_WDAY  = 7'h06;
   localparam logic [6:0] IX_DAY   = 7'h07;
   localparam logic [6:0] IX_MON   = 7'h08;
   localparam logic [6:0] IX_YEAR  = 7'h09;
   localparam logic [6:0] IX_STA   = 7'h0A;
   localparam logic [6:0] IX_STB   = 7'h0B;
   localparam logic [6:0] IX_STD   = 7'h0D;
   localparam logic [6:0] IX_CENT  = 7'h32;

   localparam logic [3:0] RATE_CODE = 4'b0110;
   localparam logic [2:0] BASE_CODE = 3'b010;
   localparam logic [7:0] STB_VALUE = 8'h06;
   localparam logic [7:0] STD_VALUE = 8'h80;

   typedef struct packed {
      logic [13:0] year;
      logic [3:0]  month;
      logic [4:0]  day;
      logic [2:0]  wday;
      logic [4:0]  hour;
      logic [5:0]  min;
      logic [5:0]  sec;
   } rtc_time_t;

   function automatic logic leap_year(input logic [13:0] y);
      return ((y % 14'd4 == 14'd0) && (y % 14'd100 != 14'd0)) || (y % 14'd400 == 14'd0);
   endfunction

   function automatic logic [4:0] month_days(input logic [3:0] m, input logic [13:0] y);
      case (m)
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         4'd2:                    return leap_year(y) ? 5'd29 : 5'd28;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
   parameter int SUBSEC_W  = 15,
   parameter int UIP_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   output logic sec_carry,
   output logic uip
);
   localparam logic [SUBSEC_W-1:0] CNT_MAX = '1;
   localparam logic [SUBSEC_W-1:0] UIP_LIM = SUBSEC_W'(UIP_TICKS);
   localparam bit UIP_POW2 = (UIP_TICKS & (UIP_TICKS - 1)) == 0;
   localparam int UIP_LOG = $clog2(UIP_TICKS);

   generate
      if (SUBSEC_W < 4 || UIP_TICKS < 1 || UIP_TICKS >= (1 << SUBSEC_W)) begin : g_bad_cfg
         $error("rtc_subsec: UIP_TICKS must lie in 1 .. 2**SUBSEC_W-1");
      end
   endgenerate

   logic [SUBSEC_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
   end

   assign sec_carry = tick_en && (cnt_q == CNT_MAX);

   generate
      if (UIP_POW2) begin : g_uip_bits
         assign uip = (cnt_q[SUBSEC_W-1:UIP_LOG] == '0);
      end else begin : g_uip_cmp
         assign uip = (cnt_q < UIP_LIM);
      end
   endgenerate

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int START_YEAR  = 2000,
   parameter int START_MONTH = 1,
   parameter int START_DAY   = 1,
   parameter int START_HOUR  = 0,
   parameter int START_MIN   = 0,
   parameter int START_SEC   = 0,
   parameter int START_WDAY  = 7
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sec_carry,
   output rtc_time_t tm
);
   localparam rtc_time_t START_TM = '{
      year:  14'(START_YEAR),  month: 4'(START_MONTH), day: 5'(START_DAY),
      wday:  3'(START_WDAY),   hour:  5'(START_HOUR),  min: 6'(START_MIN),
      sec:   6'(START_SEC)};

   generate
      if (START_YEAR < 1 || START_YEAR > 9999 || START_MONTH < 1 || START_MONTH > 12 ||
          START_DAY < 1 || START_DAY > 31 || START_HOUR > 23 || START_MIN > 59 ||
          START_SEC > 59 || START_WDAY < 1 || START_WDAY > 7) begin : g_bad_start
         $error("rtc_calendar: start date or time out of range");
      end
   endgenerate

   rtc_time_t nxt;

   always_comb begin
      nxt = tm;
      if (tm.sec != 6'd59) begin
         nxt.sec = tm.sec + 6'd1;
      end else begin
         nxt.sec = 6'd0;
         if (tm.min != 6'd59) begin
            nxt.min = tm.min + 6'd1;
         end else begin
            nxt.min = 6'd0;
            if (tm.hour != 5'd23) begin
               nxt.hour = tm.hour + 5'd1;
            end else begin
               nxt.hour = 5'd0;
               nxt.wday = (tm.wday == 3'd7) ? 3'd1 : tm.wday + 3'd1;
               if (tm.day != month_days(tm.month, tm.year)) begin
                  nxt.day = tm.day + 5'd1;
               end else begin
                  nxt.day = 5'd1;
                  if (tm.month != 4'd12) begin
                     nxt.month = tm.month + 4'd1;
                  end else begin
                     nxt.month = 4'd1;
                     nxt.year  = tm.year + 14'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         tm <= START_TM;
      else if (sec_carry) tm <= nxt;
   end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int SUBSEC_W    = 15,
   parameter int UIP_TICKS   = 8,
   parameter int START_YEAR  = 2000,
   parameter int START_MONTH = 1,
   parameter int START_DAY   = 1,
   parameter int START_HOUR  = 0,
   parameter int START_MIN   = 0,
   parameter int START_SEC   = 0,
   parameter int START_WDAY  = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       sel,
   input  logic       we,
   input  logic       offset,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);
   logic      sec_carry;
   logic      uip;
   rtc_time_t tm;
   logic [7:0] idx_q;
   logic [7:0] sel_val;
   logic [7:0] yr_lo;
   logic [7:0] century;

   rtc_subsec #(.SUBSEC_W(SUBSEC_W), .UIP_TICKS(UIP_TICKS)) u_subsec (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .sec_carry(sec_carry), .uip(uip));

   rtc_calendar #(
      .START_YEAR(START_YEAR), .START_MONTH(START_MONTH), .START_DAY(START_DAY),
      .START_HOUR(START_HOUR), .START_MIN(START_MIN), .START_SEC(START_SEC),
      .START_WDAY(START_WDAY)) u_cal (
      .clk(clk), .rst_n(rst_n), .sec_carry(sec_carry), .tm(tm));

   always_ff @(posedge clk) begin
      if (!rst_n)                   idx_q <= 8'h00;
      else if (sel && we && !offset) idx_q <= wdata;
   end

   assign yr_lo   = 8'(tm.year % 14'd100);
   assign century = 8'(tm.year / 14'd100 + 14'd1);

   always_comb begin
      case (idx_q[6:0])
         IX_SEC:  sel_val = {2'b00, tm.sec};
         IX_MIN:  sel_val = {2'b00, tm.min};
         IX_HOUR: sel_val = {3'b000, tm.hour};
         IX_WDAY: sel_val = {5'b00000, tm.wday};
         IX_DAY:  sel_val = {3'b000, tm.day};
         IX_MON:  sel_val = {4'b0000, tm.month};
         IX_YEAR: sel_val = yr_lo;
         IX_CENT: sel_val = century;
         IX_STA:  sel_val = {uip, BASE_CODE, RATE_CODE};
         IX_STB:  sel_val = STB_VALUE;
         IX_STD:  sel_val = STD_VALUE;
         default: sel_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          rdata <= 8'h00;
      else if (sel && !we) rdata <= offset ? sel_val : idx_q;
   end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
   import rtc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick_en,
   input logic       sel,
   input logic       we,
   input logic       offset,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic [7:0] idx,
   input logic       uip,
   input logic       sec_carry,
   input rtc_time_t  tm
);
   assert_idx_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && !offset) |=> (idx == $past(wdata)));

   assert_idx_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we && !offset) |=> (rdata == $past(idx)));

   assert_stb_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we && offset && idx[6:0] == 7'h0B) |=> (rdata == 8'h06));

   assert_data_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && offset && !sec_carry) |=> (tm == $past(tm) && idx == $past(idx)));

   assert_uip_after_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_carry |=> uip);

   assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(tm));

   assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && !we) |=> $stable(rdata));

   assert_cal_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tm.sec < 6'd60 && tm.min < 6'd60 && tm.hour < 5'd24 &&
       tm.wday >= 3'd1 && tm.wday <= 3'd7 && tm.month >= 4'd1 && tm.month <= 4'd12));

   assert_day_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tm.day >= 5'd1 && tm.day <= month_days(tm.month, tm.year)));

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .we(we),
   .offset(offset), .wdata(wdata), .rdata(rdata), .idx(idx_q),
   .uip(uip), .sec_carry(sec_carry), .tm(tm));

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       sel = 1'b0;
   logic       we = 1'b0;
   logic       offset = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rd_a, rd_b, rd_c, rd_d;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // dut: 2099-12-31 23:59:58 Thursday
   rtc_regfile #(.SUBSEC_W(6), .START_YEAR(2099), .START_MONTH(12), .START_DAY(31),
      .START_HOUR(23), .START_MIN(59), .START_SEC(58), .START_WDAY(5)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .we(we),
      .offset(offset), .wdata(wdata), .rdata(rd_a));
   // dut_b: 2000-02-28 23:59:59 Monday (divisible by 400, leap)
   rtc_regfile #(.SUBSEC_W(6), .START_YEAR(2000), .START_MONTH(2), .START_DAY(28),
      .START_HOUR(23), .START_MIN(59), .START_SEC(59), .START_WDAY(2)) dut_b (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .we(we),
      .offset(offset), .wdata(wdata), .rdata(rd_b));
   // dut_c: 2100-02-28 23:59:59 Sunday (divisible by 100, not leap)
   rtc_regfile #(.SUBSEC_W(6), .START_YEAR(2100), .START_MONTH(2), .START_DAY(28),
      .START_HOUR(23), .START_MIN(59), .START_SEC(59), .START_WDAY(1)) dut_c (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .we(we),
      .offset(offset), .wdata(wdata), .rdata(rd_c));
   // dut_d: 2024-03-30 23:59:59 Saturday (31-day month, weekday wrap)
   rtc_regfile #(.SUBSEC_W(6), .START_YEAR(2024), .START_MONTH(3), .START_DAY(30),
      .START_HOUR(23), .START_MIN(59), .START_SEC(59), .START_WDAY(7)) dut_d (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .we(we),
      .offset(offset), .wdata(wdata), .rdata(rd_d));

   task automatic check(input string req, input string what, input logic [7:0] got,
                        input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
      end
   endtask

   task automatic bus_write(input logic off, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; offset = off; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic bus_read(input logic off);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; offset = off;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic read_reg(input logic [7:0] ix);
      bus_write(1'b0, ix);
      bus_read(1'b1);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic t_reset_state;
      bus_read(1'b0);
      check("R12", "index after reset", rd_a, 8'h00);
      repeat (3) @(negedge clk);
      check("R13", "rdata held while idle", rd_a, 8'h00);
      read_reg(8'h00); check("R12", "seconds", rd_a, 8'd58);
      read_reg(8'h02); check("R3", "minutes", rd_a, 8'd59);
      read_reg(8'h04); check("R3", "hours", rd_a, 8'd23);
      read_reg(8'h06); check("R3", "weekday", rd_a, 8'd5);
      read_reg(8'h07); check("R3", "day", rd_a, 8'd31);
      read_reg(8'h08); check("R3", "month", rd_a, 8'd12);
      read_reg(8'h09); check("R3", "year lo", rd_a, 8'd99);
      read_reg(8'h32); check("R4", "century 2099", rd_a, 8'd21);
      check("R4", "century 2000", rd_b, 8'd21);
   endtask

   task automatic t_update_flag;
      read_reg(8'h0A); check("R5", "status A at tick 0", rd_a, 8'hA6);
      ticks(7);
      bus_read(1'b1); check("R5", "status A at tick 7", rd_a, 8'hA6);
      ticks(1);
      bus_read(1'b1); check("R5", "status A at tick 8", rd_a, 8'h26);
   endtask

   task automatic t_index_decode;
      bus_write(1'b0, 8'h8B);
      bus_read(1'b0); check("R1", "index readback 0x8B", rd_a, 8'h8B);
      bus_read(1'b1); check("R2", "bit7 ignored, status B", rd_a, 8'h06);
      read_reg(8'h0B); check("R6", "status B", rd_a, 8'h06);
      read_reg(8'h8D); check("R6", "status D", rd_a, 8'h80);
      read_reg(8'h80); check("R2", "bit7 ignored, seconds", rd_a, 8'd58);
      read_reg(8'h01); check("R7", "index 0x01", rd_a, 8'h00);
      read_reg(8'h33); check("R7", "index 0x33", rd_a, 8'h00);
      read_reg(8'h7F); check("R7", "index 0x7F", rd_a, 8'h00);
   endtask

   task automatic t_data_write_ignored;
      bus_write(1'b0, 8'h00);
      bus_write(1'b1, 8'hFF);
      bus_read(1'b0); check("R8", "index after data write", rd_a, 8'h00);
      bus_read(1'b1); check("R8", "seconds after data write", rd_a, 8'd58);
   endtask

   task automatic t_first_second;
      ticks(56);
      read_reg(8'h00); check("R9", "second after 64 ticks", rd_a, 8'd59);
      read_reg(8'h07);
      check("R11", "leap 2000 day", rd_b, 8'd29);
      check("R11", "2100 no leap day", rd_c, 8'd1);
      check("R11", "March 31 kept", rd_d, 8'd31);
      read_reg(8'h08);
      check("R11", "leap 2000 month", rd_b, 8'd2);
      check("R11", "2100 month", rd_c, 8'd3);
      read_reg(8'h06);
      check("R10", "weekday Mon->Tue", rd_b, 8'd3);
      check("R10", "weekday Sun->Mon", rd_c, 8'd2);
      check("R10", "weekday wrap Sat->Sun", rd_d, 8'd1);
      read_reg(8'h04); check("R10", "hour wraps", rd_b, 8'd0);
   endtask

   task automatic t_year_rollover;
      ticks(63);
      read_reg(8'h00); check("R9", "no carry after 63 ticks", rd_a, 8'd59);
      ticks(1);
      bus_read(1'b1); check("R10", "seconds wrap", rd_a, 8'd0);
      read_reg(8'h02); check("R10", "minutes wrap", rd_a, 8'd0);
      read_reg(8'h04); check("R10", "hours wrap", rd_a, 8'd0);
      read_reg(8'h07); check("R11", "day Jan 1", rd_a, 8'd1);
      read_reg(8'h08); check("R11", "month Jan", rd_a, 8'd1);
      read_reg(8'h09); check("R11", "year lo 2100", rd_a, 8'd0);
      read_reg(8'h32); check("R4", "century 2100", rd_a, 8'd22);
      read_reg(8'h06); check("R10", "weekday Thu->Fri", rd_a, 8'd6);
      read_reg(8'h0A); check("R5", "flag set after carry", rd_a, 8'hA6);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_update_flag();
      t_index_decode();
      t_data_write_ignored();
      t_first_second();
      t_year_rollover();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule